// File: doc/BRIEF.md
# Banked Stack Pointer and Privilege Controller

This block holds the execution mode of a small processor core (thread or handler) and a three-bit control word. From the two it decides which of two banked 32-bit stack pointers, the main pointer or the process pointer, is visible as the active stack pointer. It also decides whether the code now running is privileged. Strobes from the exception logic move the core into and out of handler mode. A control write port is gated by the current privilege. A strobe from the floating-point unit marks that floating-point state is live. Write and adjust ports let the pipeline load the active pointer or move it by whole words for push and pop.

The pipeline sees one active pointer and one privilege bit. The banking and the gating are hidden behind them. Handler mode always works on the main pointer and is always privileged, whatever the control word holds. Every change made through an input port appears on the outputs one clock after the cycle in which that input is sampled.

Top module: `stack_mode_ctrl`

## Requirements
- R1: After synchronous reset the block is in thread mode, the control word reads 3'b000, the main pointer holds MSP_RST (default 32'h2000_1000) and is the active pointer, and the process pointer holds PSP_RST (default 0).
- R2: In thread mode, `privileged_o` is the inverse of control bit 0: bit 0 = 0 gives privileged, bit 0 = 1 gives unprivileged.
- R3: In thread mode, control bit 1 selects the active pointer: 0 selects the main pointer and 1 selects the process pointer.
- R4: In handler mode the active pointer is always the main pointer and `privileged_o` is always 1, for every value of the control word.
- R5: `exc_enter_i` puts the block in handler mode at the next clock. `exc_return_i` puts it back in thread mode at the next clock. When both are high in the same cycle, entry wins.
- R6: A control write in handler mode, or in thread mode with control bit 0 = 0, loads `ctl_wr_data_i` at the next clock. A control write in thread mode with control bit 0 = 1 is ignored.
- R7: `fp_exec_i` sets control bit 2 at the next clock. This wins over a control write in the same cycle that would clear bit 2.
- R8: `sp_wr_en_i` loads `sp_wr_data_i` into the active pointer with bits [1:0] forced to 0.
- R9: `sp_adj_en_i` moves the active pointer by 4 × `sp_adj_cnt_i` bytes, modulo 2^32. It moves down when `sp_adj_up_i` = 0 (push) and up when it is 1 (pop). The inactive pointer is left unchanged. A write in the same cycle takes precedence over the adjust.
- R10: `ctl_o` reads back the control word: bit 0 is the unprivileged flag, bit 1 selects the process pointer, bit 2 is the floating-point-active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| ctl_wr_en_i | input | 1 | Control word write strobe |
| ctl_wr_data_i | input | 3 | Control word write value |
| fp_exec_i | input | 1 | Floating-point instruction executed |
| sp_wr_en_i | input | 1 | Load the active pointer |
| sp_wr_data_i | input | SP_W | Value for the pointer load |
| sp_adj_en_i | input | 1 | Adjust the active pointer |
| sp_adj_up_i | input | 1 | Adjust direction: 1 up (pop), 0 down (push) |
| sp_adj_cnt_i | input | CNT_W | Number of words to move |
| sp_active_o | output | SP_W | Value of the active stack pointer |
| handler_mode_o | output | 1 | 1 in handler mode |
| privileged_o | output | 1 | 1 when the running code is privileged |
| ctl_o | output | 3 | Control word readback |

## Verification
The bench visits every control value in both modes. It loads each value from handler mode and then returns to thread mode. A design that let the control bits reach handler mode would show the process pointer or report unprivileged there. A design that gated writes on the wrong bit, or on the mode alone, would let an unprivileged thread rewrite its own control word or would lock out a privileged thread. The bench also sweeps push and pop over every word count and forces wrap-around below zero. It drives entry and return in the same cycle, and it drives a floating-point strobe together with a write that clears bit 2. These cases catch a wrong scale or a move applied to the wrong bank, a reversed strobe priority, and a flag that a write can clear. Pointer loads with the low bits set expose a missing alignment mask.

// File: rtl/stkmode_pkg.sv
package stkmode_pkg;

    // Execution mode of the core
    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } cpu_mode_e;

    // Which banked pointer is in use
    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_PROC = 1'b1
    } sp_bank_e;

    // Control word, packed so that bit 0 is unpriv, bit 1 use_psp, bit 2 fp_active
    typedef struct packed {
        logic fp_active;
        logic use_psp;
        logic unpriv;
    } ctl_bits_t;

    localparam int CTL_W = $bits(ctl_bits_t);

    // Operation requested on the active pointer this cycle
    typedef struct packed {
        logic wr_en;
        logic adj_en;
        logic adj_up;
    } sp_cmd_t;

    // Handler mode forces the main pointer; thread mode follows use_psp
    function automatic sp_bank_e bank_select(cpu_mode_e mode, ctl_bits_t ctl);
        if (mode == MODE_HANDLER) begin
            return BANK_MAIN;
        end
        return ctl.use_psp ? BANK_PROC : BANK_MAIN;
    endfunction

    // Handler code is always privileged; thread code follows unpriv
    function automatic logic is_privileged(cpu_mode_e mode, ctl_bits_t ctl);
        return (mode == MODE_HANDLER) || !ctl.unpriv;
    endfunction

endpackage

// File: rtl/stk_mode_fsm.sv
module stk_mode_fsm
    import stkmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      exc_enter_i,
    input  logic      exc_return_i,
    output cpu_mode_e mode_o
);

    cpu_mode_e mode_q, mode_d;

    // Entry has priority so that a back-to-back exception stays in handler mode
    always_comb begin
        mode_d = mode_q;
        if (exc_enter_i) begin
            mode_d = MODE_HANDLER;
        end else if (exc_return_i) begin
            mode_d = MODE_THREAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_THREAD;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/stk_ctl_reg.sv
module stk_ctl_reg
    import stkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cpu_mode_e        mode_i,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    input  logic             fp_exec_i,
    output ctl_bits_t        ctl_o
);

    ctl_bits_t ctl_q, ctl_d;
    logic      wr_ok;

    // The gate uses the present privilege, before any write lands
    assign wr_ok = wr_en_i && is_privileged(mode_i, ctl_q);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ok) begin
            ctl_d = ctl_bits_t'(wr_data_i);
        end
        // Hardware set of the floating-point flag overrides a software clear
        if (fp_exec_i) begin
            ctl_d.fp_active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
    parameter int              SP_W    = 32,
    parameter int              CNT_W   = 5,
    parameter int              ALIGN   = 2,
    parameter logic [SP_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  stkmode_pkg::sp_cmd_t cmd_i,
    input  logic [SP_W-1:0]   wr_data_i,
    input  logic [CNT_W-1:0]  adj_cnt_i,
    output logic [SP_W-1:0]   val_o
);

    localparam int              PAD      = SP_W - CNT_W - ALIGN;
    localparam logic [SP_W-1:0] LOW_MASK = {{(SP_W-ALIGN){1'b0}}, {ALIGN{1'b1}}};

    logic [SP_W-1:0] val_q, val_d;
    logic [SP_W-1:0] step;

    // Byte distance: word count scaled by the word size
    assign step = {{PAD{1'b0}}, adj_cnt_i, {ALIGN{1'b0}}};

    always_comb begin
        val_d = val_q;
        if (sel_i) begin
            if (cmd_i.wr_en) begin
                val_d = wr_data_i & ~LOW_MASK;
            end else if (cmd_i.adj_en) begin
                val_d = cmd_i.adj_up ? (val_q + step) : (val_q - step);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= RST_VAL & ~LOW_MASK;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/stack_mode_ctrl.sv
module stack_mode_ctrl
    import stkmode_pkg::*;
#(
    parameter int              SP_W       = 32,
    parameter int              CNT_W      = 5,
    parameter int              WORD_BYTES = 4,
    parameter logic [SP_W-1:0] MSP_RST    = 32'h2000_1000,
    parameter logic [SP_W-1:0] PSP_RST    = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_enter_i,
    input  logic             exc_return_i,
    input  logic             ctl_wr_en_i,
    input  logic [CTL_W-1:0] ctl_wr_data_i,
    input  logic             fp_exec_i,
    input  logic             sp_wr_en_i,
    input  logic [SP_W-1:0]  sp_wr_data_i,
    input  logic             sp_adj_en_i,
    input  logic             sp_adj_up_i,
    input  logic [CNT_W-1:0] sp_adj_cnt_i,
    output logic [SP_W-1:0]  sp_active_o,
    output logic             handler_mode_o,
    output logic             privileged_o,
    output logic [CTL_W-1:0] ctl_o
);

    localparam int ALIGN   = $clog2(WORD_BYTES);
    localparam int N_BANKS = 2;

    cpu_mode_e       mode;
    ctl_bits_t       ctl;
    sp_bank_e        act_bank;
    sp_cmd_t         cmd;
    logic [SP_W-1:0] bank_val [N_BANKS];
    logic [SP_W-1:0] msp_val;
    logic [SP_W-1:0] psp_val;

    stk_mode_fsm u_mode (
        .clk         (clk),
        .rst         (rst),
        .exc_enter_i (exc_enter_i),
        .exc_return_i(exc_return_i),
        .mode_o      (mode)
    );

    stk_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode),
        .wr_en_i  (ctl_wr_en_i),
        .wr_data_i(ctl_wr_data_i),
        .fp_exec_i(fp_exec_i),
        .ctl_o    (ctl)
    );

    // Bank choice from the registered mode and control word
    assign act_bank = bank_select(mode, ctl);
    assign cmd      = '{wr_en: sp_wr_en_i, adj_en: sp_adj_en_i, adj_up: sp_adj_up_i};

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam logic [SP_W-1:0] B_RST = (b == 0) ? MSP_RST : PSP_RST;
        logic sel;
        assign sel = (b == 0) ? (act_bank == BANK_MAIN) : (act_bank == BANK_PROC);

        stk_ptr_reg #(
            .SP_W   (SP_W),
            .CNT_W  (CNT_W),
            .ALIGN  (ALIGN),
            .RST_VAL(B_RST)
        ) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .sel_i    (sel),
            .cmd_i    (cmd),
            .wr_data_i(sp_wr_data_i),
            .adj_cnt_i(sp_adj_cnt_i),
            .val_o    (bank_val[b])
        );
    end

    assign msp_val = bank_val[0];
    assign psp_val = bank_val[1];

    assign sp_active_o    = (act_bank == BANK_PROC) ? psp_val : msp_val;
    assign handler_mode_o = (mode == MODE_HANDLER);
    assign privileged_o   = is_privileged(mode, ctl);
    assign ctl_o          = ctl;

endmodule

// File: rtl/stack_mode_ctrl_chk.sv
module stack_mode_ctrl_chk #(
    parameter int SP_W  = 32,
    parameter int ALIGN = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            exc_enter_i,
    input logic            exc_return_i,
    input logic            ctl_wr_en_i,
    input logic            fp_exec_i,
    input logic [SP_W-1:0] sp_active_o,
    input logic            handler_mode_o,
    input logic            privileged_o,
    input logic [2:0]      ctl_o,
    input logic [SP_W-1:0] msp_val,
    input logic [SP_W-1:0] psp_val
);

    // R4
    handler_main_chk: assert property (@(posedge clk) disable iff (rst)
        handler_mode_o |-> (sp_active_o == msp_val));

    // R4
    handler_priv_chk: assert property (@(posedge clk) disable iff (rst)
        handler_mode_o |-> privileged_o);

    // R3
    thread_proc_chk: assert property (@(posedge clk) disable iff (rst)
        (!handler_mode_o && ctl_o[1]) |-> (sp_active_o == psp_val));

    // R2
    thread_priv_chk: assert property (@(posedge clk) disable iff (rst)
        !handler_mode_o |-> (privileged_o == !ctl_o[0]));

    // R8
    sp_align_chk: assert property (@(posedge clk) disable iff (rst)
        sp_active_o[ALIGN-1:0] == '0);

    // R5
    enter_chk: assert property (@(posedge clk) disable iff (rst)
        exc_enter_i |=> handler_mode_o);

    // R5
    return_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_return_i && !exc_enter_i) |=> !handler_mode_o);

    // R6
    unpriv_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!handler_mode_o && ctl_o[0] && ctl_wr_en_i && !fp_exec_i) |=> $stable(ctl_o));

    // R7
    fp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fp_exec_i |=> ctl_o[2]);

    // R9
    idle_proc_chk: assert property (@(posedge clk) disable iff (rst)
        (handler_mode_o || !ctl_o[1]) |=> $stable(psp_val));

endmodule

bind stack_mode_ctrl stack_mode_ctrl_chk #(
    .SP_W (SP_W),
    .ALIGN(ALIGN)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .exc_enter_i   (exc_enter_i),
    .exc_return_i  (exc_return_i),
    .ctl_wr_en_i   (ctl_wr_en_i),
    .fp_exec_i     (fp_exec_i),
    .sp_active_o   (sp_active_o),
    .handler_mode_o(handler_mode_o),
    .privileged_o  (privileged_o),
    .ctl_o         (ctl_o),
    .msp_val       (msp_val),
    .psp_val       (psp_val)
);

// File: tb/sim_stack_mode_ctrl.sv
module sim_stack_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_enter_i, exc_return_i, ctl_wr_en_i, fp_exec_i;
    logic [2:0]  ctl_wr_data_i;
    logic        sp_wr_en_i, sp_adj_en_i, sp_adj_up_i;
    logic [31:0] sp_wr_data_i;
    logic [4:0]  sp_adj_cnt_i;
    logic [31:0] sp_active_o;
    logic        handler_mode_o, privileged_o;
    logic [2:0]  ctl_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model of the architectural state
    logic        m_hnd;
    logic [2:0]  m_ctl;
    logic [31:0] m_sp [2];

    always #5 clk = ~clk;

    stack_mode_ctrl u0 (
        .clk(clk), .rst(rst),
        .exc_enter_i(exc_enter_i), .exc_return_i(exc_return_i),
        .ctl_wr_en_i(ctl_wr_en_i), .ctl_wr_data_i(ctl_wr_data_i),
        .fp_exec_i(fp_exec_i),
        .sp_wr_en_i(sp_wr_en_i), .sp_wr_data_i(sp_wr_data_i),
        .sp_adj_en_i(sp_adj_en_i), .sp_adj_up_i(sp_adj_up_i),
        .sp_adj_cnt_i(sp_adj_cnt_i),
        .sp_active_o(sp_active_o), .handler_mode_o(handler_mode_o),
        .privileged_o(privileged_o), .ctl_o(ctl_o)
    );

    task automatic idle_inputs();
        exc_enter_i = 0; exc_return_i = 0; ctl_wr_en_i = 0; ctl_wr_data_i = 0;
        fp_exec_i = 0; sp_wr_en_i = 0; sp_wr_data_i = 0;
        sp_adj_en_i = 0; sp_adj_up_i = 0; sp_adj_cnt_i = 0;
    endtask

    task automatic compare(input string tag);
        logic [31:0] e_sp;
        logic        e_priv;
        e_sp   = (!m_hnd && m_ctl[1]) ? m_sp[1] : m_sp[0];
        e_priv = m_hnd || !m_ctl[0];
        checks++;
        if (sp_active_o !== e_sp || handler_mode_o !== m_hnd ||
            privileged_o !== e_priv || ctl_o !== m_ctl) begin
            fails++;
            $display("FAIL %s: sp=%h exp %h, handler=%b exp %b, priv=%b exp %b, ctl=%b exp %b",
                     tag, sp_active_o, e_sp, handler_mode_o, m_hnd,
                     privileged_o, e_priv, ctl_o, m_ctl);
        end
    endtask

    // One clocked step: drive, predict, clock, compare
    task automatic step(input string tag, input logic en, input logic rt,
                        input logic wr, input logic [2:0] wd, input logic fp,
                        input logic spw, input logic [31:0] spwd,
                        input logic adj, input logic up, input logic [4:0] cnt);
        int          bk;
        logic        n_hnd;
        logic [2:0]  n_ctl;
        exc_enter_i = en; exc_return_i = rt; ctl_wr_en_i = wr; ctl_wr_data_i = wd;
        fp_exec_i = fp; sp_wr_en_i = spw; sp_wr_data_i = spwd;
        sp_adj_en_i = adj; sp_adj_up_i = up; sp_adj_cnt_i = cnt;
        bk    = (!m_hnd && m_ctl[1]) ? 1 : 0;
        n_hnd = en ? 1'b1 : (rt ? 1'b0 : m_hnd);
        n_ctl = m_ctl;
        if (wr && (m_hnd || !m_ctl[0])) n_ctl = wd;
        if (fp) n_ctl[2] = 1'b1;
        if (spw) m_sp[bk] = spwd & 32'hFFFF_FFFC;
        else if (adj) m_sp[bk] = up ? m_sp[bk] + 32'(cnt) * 4 : m_sp[bk] - 32'(cnt) * 4;
        m_hnd = n_hnd;
        m_ctl = n_ctl;
        @(posedge clk); #1;
        idle_inputs();
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        m_hnd = 0; m_ctl = 0; m_sp[0] = 32'h2000_1000; m_sp[1] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        compare("R1");   // reset state, R10 readback of zero

        // R8: load with low bits set
        step("R8", 0,0, 0,3'b0, 0, 1,32'h1234_567B, 0,0,0);
        // R9: push and pop every count on the main pointer
        for (int c = 0; c < 32; c++) begin
            step("R9", 0,0, 0,3'b0, 0, 0,0, 1,0,5'(c));
            step("R9", 0,0, 0,3'b0, 0, 0,0, 1,1,5'(c));
        end
        // R9: wrap below zero, then write wins over adjust
        step("R9", 0,0, 0,3'b0, 0, 1,32'h0000_0004, 0,0,0);
        step("R9", 0,0, 0,3'b0, 0, 0,0, 1,0,5'd3);
        step("R9", 0,0, 0,3'b0, 0, 1,32'h0000_0800, 1,1,5'd7);

        // Every control value, seen from both modes
        for (int v = 0; v < 8; v++) begin
            step("R5", 1,0, 0,3'b0, 0, 0,0, 0,0,0);
            step("R6", 0,0, 1,3'(v), 0, 0,0, 0,0,0);         // handler write allowed
            step("R4", 0,0, 0,3'b0, 0, 1,32'h100 + 32'(v)*16 + 3, 0,0,0);
            step("R4", 0,0, 0,3'b0, 0, 0,0, 1,0,5'(v+1));
            step("R5", 0,1, 0,3'b0, 0, 0,0, 0,0,0);           // back to thread: R2/R3
            step("R3", 0,0, 0,3'b0, 0, 1,32'h4000 + 32'(v)*64 + 1, 0,0,0);
            step("R9", 0,0, 0,3'b0, 0, 0,0, 1,0,5'(2*v+1));
            step("R2", 0,0, 1,3'(~v), 0, 0,0, 0,0,0);         // ignored when bit 0 set
            step("R6", 0,0, 1,3'(v ^ 2), 0, 0,0, 0,0,0);
        end

        // R5: simultaneous entry and return, entry wins
        step("R5", 1,1, 0,3'b0, 0, 0,0, 0,0,0);
        step("R5", 1,1, 0,3'b0, 0, 0,0, 0,0,0);
        // R7: flag set beats a clearing write in handler mode
        step("R7", 0,0, 1,3'b011, 1, 0,0, 0,0,0);
        step("R7", 0,0, 1,3'b000, 0, 0,0, 0,0,0);
        step("R10", 0,0, 1,3'b110, 0, 0,0, 0,0,0);
        step("R5", 0,1, 0,3'b0, 0, 0,0, 0,0,0);
        // R7: flag set in unprivileged thread where writes are blocked
        step("R6", 1,0, 1,3'b001, 0, 0,0, 0,0,0);
        step("R6", 1,0, 1,3'b001, 0, 0,0, 0,0,0);
        step("R5", 0,1, 0,3'b0, 0, 0,0, 0,0,0);
        step("R7", 0,0, 1,3'b000, 1, 0,0, 0,0,0);
        step("R6", 0,0, 1,3'b010, 0, 0,0, 0,0,0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule